// File: doc/BRIEF.md
# MDIO Station Management Master

This block reads and writes PHY registers over the two-wire management interface (a clock line and a bidirectional data line). A request carries a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block produces the management clock from the system clock and sends a preamble of ones, followed by a clause-22 frame. For a read it releases the data line and captures the reply. It signals completion with a one-cycle done pulse, and the read result appears on `rd_data` in that same cycle.

The data line is split into an output value, an output enable and an input, so the pad's tristate buffer sits outside the block. Each transaction is 64 management-clock periods long, whether it reads or writes. Every period has a low phase of `DIV_HALF` system clocks and then a high phase of `DIV_HALF` system clocks. A request is accepted only while the block is idle.

Top module: `mdio_master`

## Requirements
- R1: After reset and after each transaction the block is idle: `busy`, `done`, `mdc` and `mdio_oe` are all 0.
- R2: While busy, `mdc` is low for exactly DIV_HALF system clocks and then high for exactly DIV_HALF system clocks, and each transaction holds 64 such periods.
- R3: The first 32 MDC periods of every transaction drive the data line (`mdio_oe`=1) with the value 1.
- R4: A read drives 14 bits MSB first in periods 32..45: start `01`, opcode `10`, PHY address, register address.
- R5: A read holds `mdio_oe` at 0 for periods 46..63 and samples `mdio_i` once per period at the MDC rising edge. `rd_data` is the last 16 samples with the earliest as the MSB, so the two turnaround samples are dropped and an all-ones reply gives 0xFFFF.
- R6: A write drives 32 bits MSB first in periods 32..63: start `01`, opcode `01`, PHY address, register address, turnaround `10`, then the 16 data bits.
- R7: `mdio_o` and `mdio_oe` change only while `mdc` is low, so they hold steady through every high phase.
- R8: `busy` rises on the clock edge that accepts a request. `done` is a single-cycle pulse 128·DIV_HALF clock edges after that edge, and `busy` falls in the same cycle.
- R9: A request presented while `busy` is 1 is ignored: the frame in progress is unchanged and no extra transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Result of the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The done pulse and the falling edge of busy are due exactly 128·DIV_HALF clock edges after the accepting edge. The bench counts falling clock edges from that accept and requires done to be first seen at exactly that count. The line's value and enable are recorded on every MDC rising edge, which is the point where a PHY samples them. The bench's PHY model updates its reply bit just after each rising edge, a full period before the next rising edge, when the master samples it. Phase lengths are measured at falling clock edges, away from the edges where the registers update.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int TOTAL_BITS = 64;
    localparam int HDR_BITS   = 14;
    localparam int RD_DRIVEN  = PRE_BITS + HDR_BITS;
    localparam int BIT_W      = $clog2(TOTAL_BITS);

    typedef struct packed {
        logic             active;
        logic             wr;
        logic [BIT_W-1:0] bitn;
        logic [31:0]      shreg;
        logic [17:0]      capt;
        logic [15:0]      rdata;
        logic             done;
    } seq_state_t;

    function automatic logic [31:0] build_frame(input logic wr, input logic [4:0] phy,
                                                input logic [4:0] rg, input logic [15:0] wd);
        if (wr)
            return {2'b01, 2'b01, phy, rg, 2'b10, wd};
        else
            return {2'b01, 2'b10, phy, rg, 18'h3FFFF};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc_hi,
    output logic sample_stb,
    output logic bit_end
);
    localparam int PW = (2 * DIV_HALF > 2) ? $clog2(2 * DIV_HALF) : 1;
    localparam logic [PW-1:0] LAST = PW'(2 * DIV_HALF - 1);
    localparam logic [PW-1:0] HALF = PW'(DIV_HALF);
    localparam logic [PW-1:0] SAMP = PW'(DIV_HALF - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run || cnt_q == LAST)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign mdc_hi     = run && (cnt_q >= HALF);
    assign sample_stb = run && (cnt_q == SAMP);
    assign bit_end    = run && (cnt_q == LAST);

    // R2
    low_to_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> mdc_hi);

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    input  logic        sample_stb,
    input  logic        bit_end,
    input  logic        mdio_i,
    output logic        active,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam logic [BIT_W-1:0] PRE_L  = BIT_W'(PRE_BITS);
    localparam logic [BIT_W-1:0] RDD_L  = BIT_W'(RD_DRIVEN);
    localparam logic [BIT_W-1:0] LAST_L = BIT_W'(TOTAL_BITS - 1);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.active) begin
            if (req_valid) begin
                st_d.active = 1'b1;
                st_d.wr     = req_write;
                st_d.bitn   = '0;
                st_d.shreg  = build_frame(req_write, req_phy, req_reg, req_wdata);
                st_d.capt   = '0;
            end
        end else begin
            if (sample_stb && !st_q.wr && st_q.bitn >= RDD_L)
                st_d.capt = {st_q.capt[16:0], mdio_i};
            if (bit_end) begin
                if (st_q.bitn >= PRE_L)
                    st_d.shreg = {st_q.shreg[30:0], 1'b0};
                if (st_q.bitn == LAST_L) begin
                    st_d.active = 1'b0;
                    st_d.done   = 1'b1;
                    if (!st_q.wr)
                        st_d.rdata = st_q.capt[15:0];
                end else begin
                    st_d.bitn = st_q.bitn + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign active  = st_q.active;
    assign done    = st_q.done;
    assign rd_data = st_q.rdata;
    assign mdio_o  = st_q.active && ((st_q.bitn < PRE_L) || st_q.shreg[31]);
    assign mdio_oe = st_q.active && ((st_q.bitn < RDD_L) || st_q.wr);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && $past(st_q.active)) |-> $stable(st_q.wr));

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int DIV_HALF = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic run, sample_stb, bit_end, mdc_hi;

    mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .mdc_hi     (mdc_hi),
        .sample_stb (sample_stb),
        .bit_end    (bit_end)
    );

    mdio_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_phy    (req_phy),
        .req_reg    (req_reg),
        .req_wdata  (req_wdata),
        .sample_stb (sample_stb),
        .bit_end    (bit_end),
        .mdio_i     (mdio_i),
        .active     (run),
        .done       (done),
        .rd_data    (rd_data),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

    assign busy = run;
    assign mdc  = mdc_hi;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R8
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    logic        o_log  [64];
    logic        oe_log [64];
    int          rise_n = 0;
    logic [15:0] reply = '0;
    int          hi_run = 0, lo_run = 0, phase_bad = 0, hold_bad = 0;
    logic        prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;

    always #4 clk = ~clk;

    mdio_master #(.DIV_HALF(H)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    function automatic logic phy_bit(input int k, input logic [15:0] v);
        if (k >= 48 && k <= 63) return v[63 - k];
        return 1'b1;
    endfunction

    always @(posedge mdc) begin
        if (rise_n < 64) begin
            o_log[rise_n]  = mdio_o;
            oe_log[rise_n] = mdio_oe;
        end
        rise_n = rise_n + 1;
        mdio_i = phy_bit(rise_n, reply);
    end

    always @(negedge clk) begin
        if (mdc) begin
            hi_run = hi_run + 1;
            if (lo_run != 0 && lo_run != H) phase_bad = phase_bad + 1;
            lo_run = 0;
            if (prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe)) hold_bad = hold_bad + 1;
        end else begin
            if (busy) lo_run = lo_run + 1;
            if (hi_run != 0 && hi_run != H) phase_bad = phase_bad + 1;
            hi_run = 0;
        end
        prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_txn(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [15:0] rv, input bit inject);
        int k;
        int bad_pre, bad_body, bad_rel;
        logic [31:0] exp_body;
        reply = rv;
        rise_n = 0;
        phase_bad = 0;
        hold_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, "R8 busy after accept", busy, 1);
        k = 0;
        while (done !== 1'b1 && k < 2000) begin
            @(negedge clk);
            k++;
            if (inject && k == 50) begin
                req_valid = 1'b1; req_write = ~wr; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
            end
            if (inject && k == 51) req_valid = 1'b0;
        end
        check(k == 128 * H, "R8 done latency", k, 128 * H);
        check(busy === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0, "R1 idle after done",
              {busy, mdc, mdio_oe}, 0);
        check(rise_n == 64 && phase_bad == 0, "R2 mdc periods/phases", rise_n * 1000 + phase_bad, 64000);
        check(hold_bad == 0, "R7 line steady while mdc high", hold_bad, 0);
        bad_pre = 0;
        for (int i = 0; i < 32; i++)
            if (o_log[i] !== 1'b1 || oe_log[i] !== 1'b1) bad_pre++;
        check(bad_pre == 0, "R3 preamble", bad_pre, 0);
        exp_body = wr ? {2'b01, 2'b01, phy, rg, 2'b10, wd} : {2'b01, 2'b10, phy, rg, 18'h0};
        bad_body = 0;
        bad_rel = 0;
        for (int i = 0; i < 32; i++) begin
            if (wr || i < 14) begin
                if (o_log[32 + i] !== exp_body[31 - i] || oe_log[32 + i] !== 1'b1) bad_body++;
            end else begin
                if (oe_log[32 + i] !== 1'b0) bad_rel++;
            end
        end
        if (wr) begin
            check(bad_body == 0, "R6 write frame", bad_body, 0);
        end else begin
            check(bad_body == 0, "R4 read header", bad_body, 0);
            check(bad_rel == 0, "R5 line released", bad_rel, 0);
            check(rd_data === rv, "R5 read data", rd_data, rv);
        end
        @(negedge clk);
        check(done === 1'b0, "R8 done single cycle", done, 0);
    endtask

    initial begin
        logic [15:0] wd;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0,
              "R1 reset state", {busy, done, mdc, mdio_oe}, 0);
        for (int p = 0; p < 32; p++) begin
            wd = 16'((p * 16'h0841) ^ 16'h5A3C);
            run_txn(p[0], 5'(p), 5'(31 - p), wd, ~wd, 1'b0);
        end
        run_txn(1'b0, 5'd7, 5'd1, 16'h0, 16'hFFFF, 1'b0);
        run_txn(1'b0, 5'd31, 5'd31, 16'h0, 16'h0000, 1'b0);
        run_txn(1'b0, 5'd5, 5'd2, 16'h0, 16'h8001, 1'b1);
        held = rd_data;
        repeat (40) @(negedge clk);
        check(busy === 1'b0 && rd_data === held, "R9 no extra transaction", busy, 0);
        run_txn(1'b1, 5'd18, 5'd9, 16'hC0DE, 16'h0, 1'b1);
        check(rd_data === held, "R9 write leaves read result", rd_data, held);
        repeat (40) @(negedge clk);
        check(busy === 1'b0, "R9 idle after blocked request", busy, 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule